// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a four-level radix tree of translation tables held in memory. A request carries the virtual address, a write flag and a user-mode flag. The block takes the root table frame from a separate input. It then issues up to four 64-bit entry reads on its memory port, one per level. At every level it checks the entry's present, writable and supervisor-only bits. The walk ends with a single-cycle response that holds either the translated physical address or a fault. A fault reports its cause and the level at which it was found.

Each table has 512 eight-byte entries, and each level consumes nine address bits. Every mapping is treated as a 4 KB page. Only one walk is in progress at a time, and a new request is taken only when the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. While a walk is in progress, `req_valid` starts no memory read and changes no result.
- R2: The first entry read goes to `{root_frame, vaddr[47:39], 3'b000}`.
- R3: Each later read goes to `{entry[51:12] of the previous entry, index, 3'b000}`, with the index taken from `vaddr[38:30]`, then `vaddr[29:21]`, then `vaddr[20:12]`.
- R4: `mem_req` and `mem_addr` stay unchanged until a clock edge where `mem_rvalid` is high. That edge completes the read, and `mem_rdata` carries the entry.
- R5: A walk without a fault makes exactly four reads. It responds with `rsp_fault=0`, `rsp_cause=0`, `rsp_level=3` and `rsp_paddr = {last entry[51:12], vaddr[11:0]}`.
- R6: An entry with bit 0 (present) clear ends the walk with `rsp_fault=1`, `rsp_cause=1` and `rsp_level` equal to the level of that entry (0 = root). No further reads follow.
- R7: A write through an entry with bit 1 (writable) clear faults with cause 2. A read through the same entries succeeds.
- R8: A user-mode access through an entry with bit 2 (supervisor-only) set faults with cause 3. A supervisor access through the same entries succeeds.
- R9: When several checks fail on one entry, not-present (1) wins over privilege (3), which wins over write-protect (2).
- R10: Entry bit 7, bits 11:3 and bits 63:52 have no effect on the walk or on the result.
- R11: `rsp_valid` is a one-cycle pulse. It rises right after the edge that completes the last read. Each read takes 2+W cycles when the memory waits W cycles before answering.
- R12: After reset, `req_ready=1`, `mem_req=0` and `rsp_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| root_frame | input | 40 | Frame number of the root table |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 52 | Byte address of the entry |
| mem_rvalid | input | 1 | Read completes this cycle |
| mem_rdata | input | 64 | Entry data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write-protect, 3 privilege |
| rsp_level | output | 2 | Level of the fault, or 3 on success |
| rsp_paddr | output | 52 | Physical address on success |

## Verification
The bench memory waits W cycles on each read, so every read completes 2+W cycles after it was presented. A request taken at edge A therefore gets its response just after edge A+(k+1)(2+W) when level k faults, and just after edge A+4(2+W) on success. The bench counts clock edges from the accepting edge and requires the response to arrive on exactly that count. It samples on the falling edge so that it sees each registered result in the cycle it first appears. The memory model logs every read as it completes, and each logged address is compared against the expected path.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int OFF_W   = 12,
  parameter int PTE_W   = 64,
  parameter int FRAME_W = PA_W - OFF_W,
  parameter int LVL_W   = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [PTE_W-1:0]   mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [PA_W-1:0]    rsp_paddr
);
  localparam int ENT_B = PA_W - FRAME_W - IDX_W;
  localparam logic [1:0] C_NONE = 2'd0, C_NP = 2'd1, C_WP = 2'd2, C_PRIV = 2'd3;
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_t;
  state_t state;

  logic [VA_W-1:0]    va_q;
  logic               wr_q, usr_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tab[g] = va_q[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  wire                pte_p     = mem_rdata[0];
  wire                pte_rw    = mem_rdata[1];
  wire                pte_sup   = mem_rdata[2];
  wire [FRAME_W-1:0]  pte_frame = mem_rdata[OFF_W +: FRAME_W];
  logic unused_pte;
  assign unused_pte = ^{mem_rdata[PTE_W-1:OFF_W+FRAME_W], mem_rdata[OFF_W-1:3]};

  logic [1:0] cause_n;
  always_comb begin
    if (!pte_p)                 cause_n = C_NP;
    else if (usr_q && pte_sup)  cause_n = C_PRIV;
    else if (wr_q && !pte_rw)   cause_n = C_WP;
    else                        cause_n = C_NONE;
  end

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_FETCH);
  assign rsp_valid = (state == S_DONE);
  assign mem_addr  = {frame_q, idx_tab[lvl_q], {ENT_B{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      lvl_q     <= '0;
      frame_q   <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
      rsp_level <= '0;
      rsp_paddr <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          frame_q <= root_frame;
          lvl_q   <= '0;
          state   <= S_FETCH;
        end
        S_FETCH: if (mem_rvalid) begin
          if (cause_n != C_NONE) begin
            rsp_fault <= 1'b1;
            rsp_cause <= cause_n;
            rsp_level <= lvl_q;
            state     <= S_DONE;
          end else if (lvl_q == LAST) begin
            rsp_fault <= 1'b0;
            rsp_cause <= C_NONE;
            rsp_level <= lvl_q;
            rsp_paddr <= {pte_frame, va_q[OFF_W-1:0]};
            state     <= S_DONE;
          end else begin
            frame_q <= pte_frame;
            lvl_q   <= lvl_q + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int FRAME_W = 40,
  parameter int LVL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [VA_W-1:0]    req_vaddr,
  input logic [FRAME_W-1:0] root_frame,
  input logic               mem_req,
  input logic [PA_W-1:0]    mem_addr,
  input logic               mem_rvalid,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [LVL_W-1:0]   rsp_level
);
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r2_root_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req &&
      mem_addr[PA_W-1 -: FRAME_W+IDX_W] == {$past(root_frame), $past(req_vaddr[VA_W-1 -: IDX_W])});

  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));

  a_r5_ok_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_level == LVL_W'(LEVELS - 1));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r11_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_req && mem_rvalid));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
  .FRAME_W(FRAME_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .root_frame(root_frame), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_level(rsp_level)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [39:0] root_frame;
  logic        mem_req;
  logic [51:0] mem_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause, rsp_level;
  logic [51:0] rsp_paddr;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .root_frame(root_frame), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_level(rsp_level),
    .rsp_paddr(rsp_paddr)
  );

  logic [39:0] frm [5] = '{40'h00001, 40'h00022, 40'h00333, 40'h04444, 40'hABCDE};
  assign root_frame = frm[0];

  logic [63:0] pmem [logic [51:0]];
  logic [51:0] rd_log [$];
  int wait_cyc = 0;
  int cnt;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0; cnt <= 0;
    end else if (mem_req) begin
      if (cnt == wait_cyc) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pmem.exists(mem_addr) ? pmem[mem_addr] : 64'h0;
        rd_log.push_back(mem_addr);
      end else cnt <= cnt + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [51:0] ent_addr(input int lvl, input logic [47:0] va);
    return {frm[lvl], va[47-9*lvl -: 9], 3'b000};
  endfunction

  task automatic set_tables(input logic [47:0] va, input logic [11:0] f0, f1, f2, f3,
                            input logic [11:0] hi);
    logic [11:0] fl [4];
    fl = '{f0, f1, f2, f3};
    pmem.delete();
    for (int l = 0; l < 4; l++) pmem[ent_addr(l, va)] = {hi, frm[l+1], fl[l]};
  endtask

  logic r_fault; logic [1:0] r_cause, r_level; logic [51:0] r_paddr; int r_lat;

  task automatic walk(input logic [47:0] va, input logic wr, input logic usr);
    rd_log.delete();
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!rsp_valid && r_lat < 300) begin @(negedge clk); r_lat++; end
    r_fault = rsp_fault; r_cause = rsp_cause; r_level = rsp_level; r_paddr = rsp_paddr;
    @(negedge clk);
    check("R11 pulse", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic check_path(input string req, input logic [47:0] va, input int n);
    check({req, " read count"}, rd_log.size(), n);
    for (int l = 0; l < n && l < rd_log.size(); l++)
      check(l == 0 ? "R2 root read" : "R3 level read", rd_log[l], ent_addr(l, va));
  endtask

  task automatic t_reset;
    check("R12 ready", {63'b0, req_ready}, 64'd1);
    check("R12 mem_req", {63'b0, mem_req}, 64'd0);
    check("R12 rsp_valid", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic t_success(input int w, input logic [47:0] va, input logic wr, input logic usr);
    wait_cyc = w;
    set_tables(va, 12'h003, 12'h003, 12'h003, 12'h003, 12'h000);
    walk(va, wr, usr);
    check("R5 fault", {63'b0, r_fault}, 64'd0);
    check("R5 cause", r_cause, 0);
    check("R5 level", r_level, 3);
    check("R5 paddr", r_paddr, {frm[4], va[11:0]});
    check("R11 latency", r_lat, 4*(2+w));
    check_path("R5", va, 4);
  endtask

  task automatic t_not_present;
    logic [47:0] va = 48'h1357_9BDF_0246;
    wait_cyc = 1;
    set_tables(va, 12'h003, 12'h003, 12'h002, 12'h003, 12'h000);
    walk(va, 1'b0, 1'b0);
    check("R6 cause", r_cause, 1);
    check("R6 level", r_level, 2);
    check("R6 latency", r_lat, 3*3);
    check_path("R6", va, 3);
    set_tables(va, 12'h000, 12'h003, 12'h003, 12'h003, 12'h000);
    walk(va, 1'b0, 1'b0);
    check("R6 root cause", r_cause, 1);
    check("R6 root level", r_level, 0);
    check("R6 root reads", rd_log.size(), 1);
  endtask

  task automatic t_write_protect;
    logic [47:0] va = 48'hFEDC_BA98_7654;
    wait_cyc = 0;
    set_tables(va, 12'h003, 12'h001, 12'h003, 12'h003, 12'h000);
    walk(va, 1'b1, 1'b0);
    check("R7 fault", {63'b0, r_fault}, 64'd1);
    check("R7 cause", r_cause, 2);
    check("R7 level", r_level, 1);
    check("R7 latency", r_lat, 2*2);
    walk(va, 1'b0, 1'b1);
    check("R7 read ok", {63'b0, r_fault}, 64'd0);
    check("R7 read paddr", r_paddr, {frm[4], va[11:0]});
  endtask

  task automatic t_priv;
    logic [47:0] va = 48'h0A0B_0C0D_0E0F;
    wait_cyc = 2;
    set_tables(va, 12'h003, 12'h003, 12'h003, 12'h007, 12'h000);
    walk(va, 1'b0, 1'b1);
    check("R8 cause", r_cause, 3);
    check("R8 level", r_level, 3);
    walk(va, 1'b1, 1'b0);
    check("R8 supervisor ok", {63'b0, r_fault}, 64'd0);
    check("R8 supervisor paddr", r_paddr, {frm[4], va[11:0]});
  endtask

  task automatic t_priority;
    logic [47:0] va = 48'h5555_AAAA_3C3C;
    wait_cyc = 0;
    set_tables(va, 12'h005, 12'h003, 12'h003, 12'h003, 12'h000);
    walk(va, 1'b1, 1'b1);
    check("R9 priv over wp", r_cause, 3);
    set_tables(va, 12'h003, 12'h006, 12'h003, 12'h003, 12'h000);
    walk(va, 1'b1, 1'b1);
    check("R9 np over priv", r_cause, 1);
    check("R9 np level", r_level, 1);
  endtask

  task automatic t_ignore;
    logic [47:0] va = 48'h2468_ACE0_1357;
    wait_cyc = 1;
    set_tables(va, 12'hFFB, 12'hFFB, 12'hFFB, 12'hFFB, 12'hFFF);
    walk(va, 1'b1, 1'b0);
    check("R10 fault", {63'b0, r_fault}, 64'd0);
    check("R10 paddr", r_paddr, {frm[4], va[11:0]});
    check_path("R10", va, 4);
  endtask

  task automatic t_busy;
    logic [47:0] va = 48'h1111_2222_3333;
    int n = 0;
    wait_cyc = 3;
    set_tables(va, 12'h003, 12'h003, 12'h003, 12'h003, 12'h000);
    rd_log.delete();
    @(negedge clk);
    req_vaddr = va; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 48'h7777_6666_5555; req_write = 1'b1; req_user = 1'b1;
    check("R1 busy not ready", {63'b0, req_ready}, 64'd0);
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    check("R1 first result", rsp_paddr, {frm[4], va[11:0]});
    check("R1 first fault", {63'b0, rsp_fault}, 64'd0);
    check("R1 reads", rd_log.size(), 4);
    check("R4 latency with wait", n, 4*5);
    repeat (3) @(negedge clk);
    check("R1 dropped request", {63'b0, mem_req}, 64'd0);
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success(0, 48'h7F12_3456_789A, 1'b0, 1'b0);
    t_success(2, 48'h8001_FFFF_0ABC, 1'b1, 1'b1);
    t_not_present();
    t_write_protect();
    t_priv();
    t_priority();
    t_ignore();
    t_busy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule